// File: doc/BRIEF.md
# Compare-and-Skip Condition Unit

This unit resolves the conditional skip operation of a 16-bit processor. When the sequencer issues a skip operation, the unit takes a 4-bit condition field, the index of the first operand register and the values of both operand registers. It evaluates one of eight comparisons and reports whether the following instruction must be stepped over. A skip moves the program counter forward by exactly one word. That update is made by the sequencer, not by this unit.

Bit 3 of the condition field picks a loop-counter variant. In that variant the first operand is first reduced by one, wrapping modulo 2^16. The comparison then uses the reduced value, and the unit hands the reduced value back for write-back to the first register. Write-back is never requested for register 0. The sequencer holds the operands steady only for the cycle in which `issue` is accepted. The unit captures them in that cycle and replies with a one-cycle result pulse.

The control is a four-state machine. IDLE waits for an accepted issue. From IDLE it moves to DEC when bit 3 is set, and to CMP otherwise. DEC reduces the captured first operand and then always moves to CMP. CMP evaluates the condition, registers the outcome and always moves to DONE. DONE presents the result for one cycle and then always returns to IDLE.

Top module: `skip_unit`

## Requirements
- R1: `ready` is high exactly while the unit is in IDLE. An `issue` pulse is accepted only on a rising edge where `ready` is high. An `issue` raised while `ready` is low has no effect on any later result.
- R2: `result_valid` is high for exactly one cycle. For a plain condition (bit 3 = 0) it is first seen after the 2nd rising edge following acceptance. For the decrement variant (bit 3 = 1) it is first seen after the 3rd such edge.
- R3: Condition low bits 000 skip when the first operand is below the second, both unsigned. Low bits 100 skip when the first operand is unsigned greater than or equal to the second.
- R4: Condition low bits 001 skip when the first operand is below the second in two's complement. Low bits 101 skip when it is signed greater than or equal.
- R5: Condition low bits 010 skip when the operands are equal, and 110 skip when they differ.
- R6: Condition low bits 011 skip when the 16-bit unsigned sum of the operands carries out of bit 15. Low bits 111 skip when the sum does not carry.
- R7: With condition bit 3 = 1, the comparison uses the first operand minus one, modulo 2^16. `wb_val` carries that value, `wb_idx` carries the first operand's index, and `wb_en` is high with `result_valid`.
- R8: `wb_en` stays low when condition bit 3 = 0, and also when the first operand index is 0.
- R9: After reset, `ready` = 1, `result_valid` = 0, `skip` = 0 and `wb_en` = 0.
- R10: While `result_valid` is low, `skip` and `wb_en` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Request to evaluate a skip operation |
| ready | output | 1 | Unit is idle and accepts `issue` |
| cond | input | 4 | Bit 3: decrement variant; bits 2:0: condition code |
| lhs_idx | input | 4 | Register index of the first operand |
| lhs_val | input | 16 | Value of the first operand |
| rhs_val | input | 16 | Value of the second operand |
| result_valid | output | 1 | One-cycle pulse marking the result |
| skip | output | 1 | Skip the next instruction |
| wb_en | output | 1 | Write `wb_val` back to register `wb_idx` |
| wb_idx | output | 4 | Register index for write-back |
| wb_val | output | 16 | Decremented first operand |

## Verification
A wrong state register or a stray transition shows first in timing. The result pulse arrives one edge early or late, lasts two cycles, or never comes. In each case the error appears within three cycles of the accepted issue. A corrupted captured operand, or a missed decrement, shows in the same pulse: the wrong `skip` or `wb_val` appears at the first result after the fault. Condition pairs that differ only in bit 2 are run on identical operands, so an inverted or swapped code is exposed at once.

// File: rtl/skip_pkg.sv
package skip_pkg;
    localparam int REG_IDX_W = 4;
    localparam int COND_W    = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEC  = 2'd1,
        ST_CMP  = 2'd2,
        ST_DONE = 2'd3
    } skip_state_t;

    // Base comparison picked by condition bits 1:0; bit 2 inverts it.
    typedef enum logic [1:0] {
        K_ULT   = 2'd0,
        K_SLT   = 2'd1,
        K_EQ    = 2'd2,
        K_CARRY = 2'd3
    } cmp_kind_t;
endpackage

// File: rtl/skip_decrement.sv
module skip_decrement #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] val_in,
    output logic [DATA_W-1:0] val_out
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Wraps modulo 2^DATA_W: zero becomes all ones.
    always_comb begin
        val_out = val_in - ONE;
    end
endmodule

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
    import skip_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        code,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              hit
);
    localparam int SUM_W = DATA_W + 1;

    logic [SUM_W-1:0] sum_ext;
    logic             base;
    cmp_kind_t        kind;

    always_comb begin
        sum_ext = {1'b0, lhs} + {1'b0, rhs};
        kind    = cmp_kind_t'(code[1:0]);
        unique case (kind)
            K_ULT:   base = (lhs < rhs);
            K_SLT:   base = ($signed(lhs) < $signed(rhs));
            K_EQ:    base = (lhs == rhs);
            K_CARRY: base = sum_ext[SUM_W-1];
            default: base = 1'b0;
        endcase
        hit = base ^ code[2];
    end
endmodule

// File: rtl/skip_unit.sv
module skip_unit
    import skip_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    output logic                 ready,
    input  logic [COND_W-1:0]    cond,
    input  logic [REG_IDX_W-1:0] lhs_idx,
    input  logic [DATA_W-1:0]    lhs_val,
    input  logic [DATA_W-1:0]    rhs_val,
    output logic                 result_valid,
    output logic                 skip,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [DATA_W-1:0]    wb_val
);
    localparam int DEC_BIT = COND_W - 1;

    skip_state_t          state, state_nx;
    logic [COND_W-1:0]    cond_q;
    logic [REG_IDX_W-1:0] idx_q;
    logic [DATA_W-1:0]    lhs_q, rhs_q;
    logic                 skip_q;
    logic [DATA_W-1:0]    lhs_dec;
    logic                 cmp_hit;
    logic                 accept;

    skip_decrement #(.DATA_W(DATA_W)) u_dec (
        .val_in (lhs_q),
        .val_out(lhs_dec)
    );

    skip_cond_eval #(.DATA_W(DATA_W)) u_eval (
        .code(cond_q[2:0]),
        .lhs (lhs_q),
        .rhs (rhs_q),
        .hit (cmp_hit)
    );

    assign accept = issue && (state == ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (issue) state_nx = cond[DEC_BIT] ? ST_DEC : ST_CMP;
            ST_DEC:  state_nx = ST_CMP;
            ST_CMP:  state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
            idx_q  <= '0;
            lhs_q  <= '0;
            rhs_q  <= '0;
            skip_q <= 1'b0;
        end else begin
            if (accept) begin
                cond_q <= cond;
                idx_q  <= lhs_idx;
                lhs_q  <= lhs_val;
                rhs_q  <= rhs_val;
            end
            if (state == ST_DEC) lhs_q  <= lhs_dec;
            if (state == ST_CMP) skip_q <= cmp_hit;
        end
    end

    always_comb begin
        ready        = (state == ST_IDLE);
        result_valid = (state == ST_DONE);
        skip         = result_valid && skip_q;
        wb_en        = result_valid && cond_q[DEC_BIT] && (idx_q != '0);
        wb_idx       = wb_en ? idx_q : '0;
        wb_val       = wb_en ? lhs_q : '0;
    end

    p_accept_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ready) |=> !ready);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> (!result_valid && ready));

    p_dec_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ready && cond[DEC_BIT]) |=> (state == ST_DEC));

    p_wb_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (result_valid && wb_idx != '0));

    p_quiet_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> (!skip && !wb_en));
endmodule

// File: tb/skip_unit_bench.sv
module skip_unit_bench;
    typedef struct {
        logic        skip;
        logic        wb_en;
        logic [3:0]  wb_idx;
        logic [15:0] wb_val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  cond = '0;
    logic [3:0]  lhs_idx = '0;
    logic [15:0] lhs_val = '0;
    logic [15:0] rhs_val = '0;
    logic        ready, result_valid, skip, wb_en;
    logic [3:0]  wb_idx;
    logic [15:0] wb_val;

    int   checks = 0;
    int   failures = 0;
    exp_t expq[$];

    always #5 clk = ~clk;

    skip_unit u_skip_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .ready(ready),
        .cond(cond), .lhs_idx(lhs_idx), .lhs_val(lhs_val), .rhs_val(rhs_val),
        .result_valid(result_valid), .skip(skip), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_val(wb_val)
    );

    function automatic logic model_hit(logic [3:0] c, logic [15:0] a, logic [15:0] b);
        logic [15:0] x;
        logic [16:0] s;
        x = c[3] ? a - 16'd1 : a;
        s = {1'b0, x} + {1'b0, b};
        case (c[2:0])
            3'b000: return x < b;
            3'b100: return x >= b;
            3'b001: return $signed(x) < $signed(b);
            3'b101: return $signed(x) >= $signed(b);
            3'b010: return x == b;
            3'b110: return x != b;
            3'b011: return s[16];
            default: return !s[16];
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: pushes the expected item, issues, and checks latency (R2).
    // With junk set, it raises issue again while busy (R1).
    task automatic run_op(string tag, logic [3:0] c, logic [3:0] idx,
                          logic [15:0] a, logic [15:0] b, bit junk);
        exp_t e;
        int   lat;
        e.skip   = model_hit(c, a, b);
        e.wb_en  = c[3] && (idx != 4'd0);
        e.wb_idx = e.wb_en ? idx : 4'd0;
        e.wb_val = e.wb_en ? a - 16'd1 : 16'd0;
        e.tag    = tag;
        @(negedge clk);
        while (!ready) @(negedge clk);
        expq.push_back(e);
        cond = c; lhs_idx = idx; lhs_val = a; rhs_val = b; issue = 1'b1;
        @(negedge clk);
        lat = 1;
        if (junk) begin
            check("R1 ready low while busy", {31'd0, ready}, 32'd0);
            cond = ~c; lhs_idx = ~idx; lhs_val = ~a; rhs_val = ~b;
        end else begin
            issue = 1'b0;
        end
        while (!result_valid && lat < 10) begin
            @(negedge clk);
            issue = 1'b0;
            lat++;
        end
        issue = 1'b0;
        check({"R2 latency ", tag}, lat, c[3] ? 3 : 2);
        @(negedge clk);
        check("R2 pulse one cycle", {31'd0, result_valid}, 32'd0);
        check("R1 ready after done", {31'd0, ready}, 32'd1);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compares every result pulse against the queue head (R10 too).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (result_valid) begin
                    if (expq.size() == 0) begin
                        check("R1 unexpected result", 32'd1, 32'd0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        check({e.tag, " skip"}, {31'd0, skip}, {31'd0, e.skip});
                        check({e.tag, " wb_en"}, {31'd0, wb_en}, {31'd0, e.wb_en});
                        check({e.tag, " wb_idx"}, {28'd0, wb_idx}, {28'd0, e.wb_idx});
                        check({e.tag, " wb_val"}, {16'd0, wb_val}, {16'd0, e.wb_val});
                    end
                end else if (skip || wb_en) begin
                    check("R10 outputs quiet", {30'd0, skip, wb_en}, 32'd0);
                end
            end
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9 ready", {31'd0, ready}, 32'd1);
        check("R9 valid", {31'd0, result_valid}, 32'd0);
        check("R9 skip/wb", {30'd0, skip, wb_en}, 32'd0);
        rst_n = 1'b1;

        // R3 unsigned pair
        run_op("R3", 4'b0000, 4'd2, 16'h0001, 16'h8000, 0);
        run_op("R3", 4'b0100, 4'd2, 16'h0001, 16'h8000, 0);
        run_op("R3", 4'b0000, 4'd2, 16'h1234, 16'h1234, 0);
        run_op("R3", 4'b0100, 4'd2, 16'h1234, 16'h1234, 0);
        // R4 signed pair: 0x8000 is negative
        run_op("R4", 4'b0001, 4'd3, 16'h8000, 16'h0001, 0);
        run_op("R4", 4'b0101, 4'd3, 16'h8000, 16'h0001, 0);
        run_op("R4", 4'b0001, 4'd3, 16'h7FFF, 16'hFFFF, 0);
        // R5 equality pair
        run_op("R5", 4'b0010, 4'd4, 16'hBEEF, 16'hBEEF, 0);
        run_op("R5", 4'b0110, 4'd4, 16'hBEEF, 16'hBEEF, 0);
        run_op("R5", 4'b0110, 4'd4, 16'hBEEF, 16'hBEEE, 0);
        // R6 carry pair: 0xFFFF+1 carries, 0xFFFE+1 does not
        run_op("R6", 4'b0011, 4'd5, 16'hFFFF, 16'h0001, 0);
        run_op("R6", 4'b0111, 4'd5, 16'hFFFF, 16'h0001, 0);
        run_op("R6", 4'b0011, 4'd5, 16'hFFFE, 16'h0001, 0);
        run_op("R6", 4'b0111, 4'd5, 16'hFFFE, 16'h0001, 0);
        // R7 decrement variant
        run_op("R7", 4'b1010, 4'd6, 16'h0001, 16'h0000, 0);
        run_op("R7", 4'b1110, 4'd6, 16'h0005, 16'h0000, 0);
        run_op("R7", 4'b1000, 4'd7, 16'h0000, 16'h0001, 0);
        run_op("R7", 4'b1001, 4'd7, 16'h0000, 16'h0000, 0);
        run_op("R7", 4'b1011, 4'd9, 16'h0001, 16'hFFFF, 0);
        // R8 write-back suppressed for register 0 and for plain codes
        run_op("R8", 4'b1010, 4'd0, 16'h0001, 16'h0000, 0);
        run_op("R8", 4'b0010, 4'd8, 16'h0001, 16'h0000, 0);
        // R1 issue while busy is ignored
        run_op("R1", 4'b0000, 4'd2, 16'h0003, 16'h0004, 1);
        run_op("R1", 4'b1110, 4'd11, 16'h0002, 16'h0001, 1);

        repeat (5) @(negedge clk);
        check("R1 no leftover results", expq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule